// File: doc/BRIEF.md
# Status Word Trap and Relocation Controller

This block keeps the processor status word of a simple two-mode machine. The word has four fields: a privilege mode, a relocation base, a length limit and a program counter. Each virtual address that the core presents is compared with the length limit. If it is inside the limit, the block returns the base plus the address as the physical address, in the same cycle. The block does not contain the instruction decoder, the datapath or the memory.

A trap can come from three places: an explicit trap request, an address at or beyond the length limit, or a status-word load issued from user mode. A trap starts a fixed four-state machine. In IDLE the block translates addresses and accepts commands. IDLE moves to SAVE on any trap condition. SAVE writes the current status word to physical word 0 and moves to LOAD when the write is acknowledged. LOAD reads physical word 1 and moves to DONE when the read is acknowledged; the word it reads becomes the new status word. DONE lasts one cycle and returns to IDLE. A supervisor launches or resumes a task by issuing a status-word load, which replaces all four fields in one cycle without touching memory.

Top module: `psw_trap_unit`

## Requirements
- R1: After reset the mode is supervisor (mode bit 0), the base is 0, the length is 2^AW (the whole physical space), the PC is 0, `busy` is low and `mem_req` is low.
- R2: In IDLE, with `xlat_valid` high and `xlat_vaddr` < length, `xlat_ok` is high in the same cycle and `xlat_paddr` equals (base + vaddr) mod 2^AW.
- R3: In IDLE, with `xlat_valid` high and `xlat_vaddr` >= length, `xlat_ok` stays low and a bounds trap starts at the next edge. A core PC write in that same cycle is discarded, so the saved PC is the PC of the faulting instruction.
- R4: In the cycle after a trap edge, `mem_req`=1, `mem_we`=1, `mem_addr`=0 and `mem_wdata` holds the status word as it was before the trap. These values hold until `mem_ack` is seen.
- R5: In the cycle after the write is acknowledged, `mem_req`=1, `mem_we`=0 and `mem_addr`=1, held until `mem_ack`. The status word then equals the `mem_rdata` value that was present with that acknowledge.
- R6: A trap sequence writes memory exactly once, and that write goes to physical word 0.
- R7: A memory status word is packed as {mode, base[AW], length[AW+1], pc[AW]} with the mode in the MSB; mode 0 means supervisor and 1 means user.
- R8: A status-word load in supervisor mode replaces all four fields at the next edge and makes no memory access.
- R9: A status-word load in user mode causes a trap instead, and the saved word is the user status word that was current.
- R10: From SAVE through DONE, the block ignores trap requests, status-word loads, core PC writes and translation requests, and `xlat_ok` stays low.
- R11: `busy` is high from SAVE through DONE. DONE lasts exactly one cycle, after which the block returns to IDLE with `mem_req` low.
- R12: In IDLE, with no trap, a core PC write sets the PC at the next edge.
- R13: A trap request takes precedence over a status-word load that is legal and arrives in the same cycle; that load is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xlat_valid | input | 1 | Core presents a virtual address |
| xlat_vaddr | input | AW | Virtual address |
| xlat_ok | output | 1 | Address is legal; the access may proceed |
| xlat_paddr | output | AW | Relocated physical address |
| trap_req | input | 1 | Explicit trap request from the core |
| lpsw_valid | input | 1 | Load-status-word command |
| lpsw_word | input | WW | Packed status word for that command |
| core_pc_wr | input | 1 | Core updates the PC |
| core_pc | input | AW | New PC value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Physical word address |
| mem_wdata | output | WW | Write data (saved status word) |
| mem_ack | input | 1 | Request accepted |
| mem_rdata | input | WW | Read data (new status word) |
| psw_mode | output | 1 | Current mode, 0 = supervisor |
| psw_base | output | AW | Current relocation base |
| psw_len | output | AW+1 | Current length limit |
| psw_pc | output | AW | Current program counter |
| busy | output | 1 | Trap sequence in progress |

## Verification
Translation is checked exhaustively on a small configuration: every base is combined with every length, including zero and the full space, and every virtual address is presented under each pair. This separates correct wrap-around of the physical address from errors in the limit comparison at v = L-1 and at v = L. Separate trap scenarios cover bounds faults, status-word loads from user mode, and explicit requests that collide with a legal load. Each scenario uses its own acknowledge latency, so the saved word, the holding of each request and the new status word can be checked independently. Commands injected while a sequence runs show whether the block ignores them.

// File: rtl/psw_pkg.sv
package psw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SAVE = 2'd1,
        ST_LOAD = 2'd2,
        ST_DONE = 2'd3
    } seq_state_e;

    localparam logic MODE_SUP = 1'b0;
    localparam logic MODE_USR = 1'b1;

endpackage

// File: rtl/psw_xlat.sv
module psw_xlat #(
    parameter int AW = 8,
    localparam int LW = AW + 1
) (
    input  logic [AW-1:0] vaddr,
    input  logic [AW-1:0] base,
    input  logic [LW-1:0] len,
    output logic [AW-1:0] paddr,
    output logic          in_bounds
);

    // Zero-extend the address so that the full-space length (2^AW) compares correctly.
    always_comb begin
        in_bounds = ({1'b0, vaddr} < len);
        paddr     = base + vaddr;
    end

endmodule

// File: rtl/psw_seq.sv
module psw_seq
    import psw_pkg::*;
#(
    parameter int AW = 8,
    parameter int WW = 3 * AW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig,
    input  logic [WW-1:0] cur_word,
    input  logic          mem_ack,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [WW-1:0] mem_wdata,
    output logic          load_fire,
    output logic          busy
);

    localparam logic [AW-1:0] SAVE_SLOT = '0;
    localparam logic [AW-1:0] LOAD_SLOT = AW'(1);

    seq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (trig)    state_d = ST_SAVE;
            ST_SAVE: if (mem_ack) state_d = ST_LOAD;
            ST_LOAD: if (mem_ack) state_d = ST_DONE;
            ST_DONE:              state_d = ST_IDLE;
            default:              state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = SAVE_SLOT;
        mem_wdata = cur_word;
        load_fire = 1'b0;
        busy      = 1'b1;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_SAVE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_LOAD: begin
                mem_req   = 1'b1;
                mem_addr  = LOAD_SLOT;
                load_fire = mem_ack;
            end
            ST_DONE: ;
            default: busy = 1'b0;
        endcase
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr))); // R4
    AST_WRITE_ONLY_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr == SAVE_SLOT)); // R6
    AST_LOAD_AFTER_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we && mem_addr == LOAD_SLOT)); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_req) |=> !busy); // R11

endmodule

// File: rtl/psw_reg.sv
module psw_reg
    import psw_pkg::*;
#(
    parameter int AW = 8,
    localparam int LW = AW + 1,
    localparam int WW = 1 + AW + LW + AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trap_ld,
    input  logic [WW-1:0] trap_word,
    input  logic          cmd_ld,
    input  logic [WW-1:0] cmd_word,
    input  logic          pc_wr,
    input  logic [AW-1:0] pc_val,
    output logic          mode,
    output logic [AW-1:0] base,
    output logic [LW-1:0] len,
    output logic [AW-1:0] pc,
    output logic [WW-1:0] word
);

    localparam logic [LW-1:0] LEN_FULL = {1'b1, {AW{1'b0}}};
    localparam int PC_LSB   = 0;
    localparam int LEN_LSB  = AW;
    localparam int BASE_LSB = AW + LW;
    localparam int MODE_BIT = WW - 1;

    logic [WW-1:0] src;

    always_comb src = trap_ld ? trap_word : cmd_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= MODE_SUP;
            base <= '0;
            len  <= LEN_FULL;
            pc   <= '0;
        end else if (trap_ld || cmd_ld) begin
            mode <= src[MODE_BIT];
            base <= src[BASE_LSB +: AW];
            len  <= src[LEN_LSB +: LW];
            pc   <= src[PC_LSB +: AW];
        end else if (pc_wr) begin
            pc <= pc_val;
        end
    end

    always_comb word = {mode, base, len, pc};

    AST_TRAP_WORD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        trap_ld |=> (word == $past(trap_word))); // R5
    AST_CMD_WORD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ld && !trap_ld) |=> (word == $past(cmd_word))); // R8

endmodule

// File: rtl/psw_trap_unit.sv
module psw_trap_unit
    import psw_pkg::*;
#(
    parameter int AW = 8,
    localparam int LW = AW + 1,
    localparam int WW = 1 + AW + LW + AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xlat_valid,
    input  logic [AW-1:0] xlat_vaddr,
    output logic          xlat_ok,
    output logic [AW-1:0] xlat_paddr,
    input  logic          trap_req,
    input  logic          lpsw_valid,
    input  logic [WW-1:0] lpsw_word,
    input  logic          core_pc_wr,
    input  logic [AW-1:0] core_pc,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [WW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [WW-1:0] mem_rdata,
    output logic          psw_mode,
    output logic [AW-1:0] psw_base,
    output logic [LW-1:0] psw_len,
    output logic [AW-1:0] psw_pc,
    output logic          busy
);

    logic          in_bounds;
    logic          idle;
    logic          oob_fault;
    logic          priv_fault;
    logic          trig;
    logic          cmd_ld;
    logic          pc_wr;
    logic          load_fire;
    logic [WW-1:0] psw_word;

    psw_xlat #(.AW(AW)) u_xlat (
        .vaddr     (xlat_vaddr),
        .base      (psw_base),
        .len       (psw_len),
        .paddr     (xlat_paddr),
        .in_bounds (in_bounds)
    );

    always_comb begin
        idle       = !busy;
        oob_fault  = xlat_valid && !in_bounds;
        priv_fault = lpsw_valid && (psw_mode == MODE_USR);
        trig       = idle && (trap_req || oob_fault || priv_fault);
        cmd_ld     = idle && lpsw_valid && (psw_mode == MODE_SUP) && !trap_req && !oob_fault;
        pc_wr      = idle && core_pc_wr && !trig;
        xlat_ok    = idle && xlat_valid && in_bounds;
    end

    psw_seq #(.AW(AW), .WW(WW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .cur_word  (psw_word),
        .mem_ack   (mem_ack),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .load_fire (load_fire),
        .busy      (busy)
    );

    psw_reg #(.AW(AW)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .trap_ld   (load_fire),
        .trap_word (mem_rdata),
        .cmd_ld    (cmd_ld),
        .cmd_word  (lpsw_word),
        .pc_wr     (pc_wr),
        .pc_val    (core_pc),
        .mode      (psw_mode),
        .base      (psw_base),
        .len       (psw_len),
        .pc        (psw_pc),
        .word      (psw_word)
    );

    AST_OK_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_ok |-> ({1'b0, xlat_vaddr} < psw_len)); // R2
    AST_PSW_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load_fire) |=> $stable(psw_word)); // R10
    AST_SAVE_IS_CURRENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata == psw_word)); // R4
    AST_FAULT_STARTS_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && xlat_valid && !in_bounds) |=> (mem_req && mem_we)); // R3

endmodule

// File: tb/test_psw_trap_unit.sv
module test_psw_trap_unit;

    localparam int AW = 4;
    localparam int LW = AW + 1;
    localparam int WW = 1 + AW + LW + AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          xlat_valid = 1'b0;
    logic [AW-1:0] xlat_vaddr = '0;
    logic          xlat_ok;
    logic [AW-1:0] xlat_paddr;
    logic          trap_req = 1'b0;
    logic          lpsw_valid = 1'b0;
    logic [WW-1:0] lpsw_word = '0;
    logic          core_pc_wr = 1'b0;
    logic [AW-1:0] core_pc = '0;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [WW-1:0] mem_wdata;
    logic          mem_ack = 1'b0;
    logic [WW-1:0] mem_rdata = '0;
    logic          psw_mode;
    logic [AW-1:0] psw_base;
    logic [LW-1:0] psw_len;
    logic [AW-1:0] psw_pc;
    logic          busy;

    int checks = 0;
    int errors = 0;
    int writes = 0;
    int bad_writes = 0;

    always #4 clk = ~clk;

    psw_trap_unit #(.AW(AW)) i_psw_trap_unit (
        .clk(clk), .rst_n(rst_n),
        .xlat_valid(xlat_valid), .xlat_vaddr(xlat_vaddr),
        .xlat_ok(xlat_ok), .xlat_paddr(xlat_paddr),
        .trap_req(trap_req), .lpsw_valid(lpsw_valid), .lpsw_word(lpsw_word),
        .core_pc_wr(core_pc_wr), .core_pc(core_pc),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .psw_mode(psw_mode), .psw_base(psw_base), .psw_len(psw_len),
        .psw_pc(psw_pc), .busy(busy)
    );

    // R6: count accepted writes and any that go anywhere but word 0
    always @(posedge clk) begin
        if (rst_n && mem_req && mem_we && mem_ack) begin
            writes++;
            if (mem_addr != '0) bad_writes++;
        end
    end

    function automatic logic [WW-1:0] pk(input int m, input int b, input int l, input int p);
        pk = {1'(m), AW'(b), LW'(l), AW'(p)};   // R7 packing
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] cur_psw();
        cur_psw = {psw_mode, psw_base, psw_len, psw_pc};
    endfunction

    task automatic load_cmd(input logic [WW-1:0] w);
        @(negedge clk);
        lpsw_valid = 1'b1;
        lpsw_word  = w;
        @(negedge clk);
        lpsw_valid = 1'b0;
    endtask

    // Called at the negedge right after the trap edge.
    task automatic serve_trap(input logic [WW-1:0] saved, input logic [WW-1:0] handler,
                              input int lat, input string tag);
        chk({tag, " R11 busy in SAVE"}, 32'(busy), 1);
        chk({tag, " R4 save req"}, {29'd0, mem_req, mem_we, 1'b0}, {29'd0, 1'b1, 1'b1, 1'b0});
        chk({tag, " R4 save addr"}, 32'(mem_addr), 0);
        chk({tag, " R4 saved word"}, 32'(mem_wdata), 32'(saved));
        for (int i = 0; i < lat; i++) begin
            if (i == 0) begin
                trap_req   = 1'b1;
                lpsw_valid = 1'b1;
                lpsw_word  = pk(0, 3, 3, 3);
                core_pc_wr = 1'b1;
                core_pc    = AW'(7);
                xlat_valid = 1'b1;
                xlat_vaddr = '0;
                #1;
                chk({tag, " R10 xlat_ok low while busy"}, 32'(xlat_ok), 0);
            end
            @(negedge clk);
            trap_req = 1'b0; lpsw_valid = 1'b0; core_pc_wr = 1'b0; xlat_valid = 1'b0;
            chk({tag, " R4 save held"}, {30'd0, mem_req, mem_we}, 32'd3);
            chk({tag, " R4 save addr held"}, 32'(mem_addr), 0);
        end
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        chk({tag, " R5 load req"}, {30'd0, mem_req, mem_we}, 32'd2);
        chk({tag, " R5 load addr"}, 32'(mem_addr), 1);
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            chk({tag, " R5 load held"}, {30'd0, mem_req, mem_we}, 32'd2);
        end
        mem_rdata = handler;
        mem_ack   = 1'b1;
        @(negedge clk);
        mem_ack   = 1'b0;
        mem_rdata = '0;
        chk({tag, " R11 busy in DONE"}, 32'(busy), 1);
        chk({tag, " R11 no req in DONE"}, 32'(mem_req), 0);
        chk({tag, " R5 new word / R10 commands ignored"}, 32'(cur_psw()), 32'(handler));
        @(negedge clk);
        chk({tag, " R11 back to idle"}, 32'(busy), 0);
        chk({tag, " R10 no second sequence"}, 32'(mem_req), 0);
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int ntraps = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 mode", 32'(psw_mode), 0);
        chk("R1 base", 32'(psw_base), 0);
        chk("R1 len", 32'(psw_len), 16);
        chk("R1 pc", 32'(psw_pc), 0);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 mem_req", 32'(mem_req), 0);

        // R2/R3/R8: exhaustive translation sweep in supervisor mode
        for (int b = 0; b < 16; b++) begin
            for (int l = 0; l <= 16; l++) begin
                load_cmd(pk(0, b, l, (b + l) % 16));
                chk("R8 loaded word", 32'(cur_psw()), 32'(pk(0, b, l, (b + l) % 16)));
                chk("R8 no memory access", 32'(mem_req), 0);
                for (int v = 0; v < 16; v++) begin
                    @(negedge clk);
                    xlat_valid = 1'b1;
                    xlat_vaddr = AW'(v);
                    #1;
                    chk(v < l ? "R2 ok in range" : "R3 ok low out of range",
                        32'(xlat_ok), (v < l) ? 1 : 0);
                    if (v < l) chk("R2 paddr", 32'(xlat_paddr), (b + v) % 16);
                    xlat_valid = 1'b0;
                end
            end
        end

        // R12 core PC write in idle
        @(negedge clk);
        core_pc_wr = 1'b1;
        core_pc    = AW'(9);
        @(negedge clk);
        core_pc_wr = 1'b0;
        chk("R12 pc written", 32'(psw_pc), 9);

        // R3 bounds traps with several limits and ack latencies
        for (int i = 0; i < 4; i++) begin
            int b = i * 5;
            int l = i + 2;
            int p = i + 3;
            load_cmd(pk(1, b, l, p));
            @(negedge clk);
            xlat_valid = 1'b1;
            xlat_vaddr = AW'(l + i);
            core_pc_wr = 1'b1;
            core_pc    = AW'(p + 1);
            #1;
            chk("R3 fault not ok", 32'(xlat_ok), 0);
            @(negedge clk);
            xlat_valid = 1'b0;
            core_pc_wr = 1'b0;
            serve_trap(pk(1, b, l, p), pk(0, 0, 16, 10 + i), i, "R3");
            ntraps++;
        end

        // R9 privileged load from user mode
        load_cmd(pk(1, 2, 4, 6));
        chk("R9 user word loaded", 32'(cur_psw()), 32'(pk(1, 2, 4, 6)));
        @(negedge clk);
        lpsw_valid = 1'b1;
        lpsw_word  = pk(0, 9, 9, 9);
        @(negedge clk);
        lpsw_valid = 1'b0;
        serve_trap(pk(1, 2, 4, 6), pk(0, 0, 16, 1), 2, "R9");
        ntraps++;

        // R13 explicit trap beats a legal load in the same cycle
        @(negedge clk);
        trap_req   = 1'b1;
        lpsw_valid = 1'b1;
        lpsw_word  = pk(1, 5, 5, 5);
        @(negedge clk);
        trap_req   = 1'b0;
        lpsw_valid = 1'b0;
        serve_trap(pk(0, 0, 16, 1), pk(0, 0, 16, 2), 1, "R13");
        ntraps++;

        // R6 one write per trap, all to word 0
        chk("R6 stray writes", 32'(bad_writes), 0);
        chk("R6 write count", 32'(writes), 32'(ntraps));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule